// File: doc/BRIEF.md
# GPIO Set/Clear Register Bank

A register-mapped general-purpose I/O block for a simple 32-bit register bus. It drives a value and an output enable for each pin. It also samples each pin's input level through a synchronizer. Output levels and driver enables are never written as whole words. Each has one register that raises the bits marked with a 1 and another that lowers them. Software can therefore change one pin without first reading the register and writing it back.

Bus accesses are single-cycle. A request with `we_i` high performs a write, and the new latch state reaches the pins on the clock edge that accepts it. A request with `we_i` low performs a read, and the read data appears on `rdata_o` after that same edge. `rdata_o` then holds until the next read. Offsets are byte addresses compared on the full `addr_i`. Pin n always sits at bit n of every register.

Top module: `gpio_sc_bank`

## Requirements
- R1: After reset `pin_o`, `pin_oe_o` and `rdata_o` are all zero, so every pin is tristated.
- R2: A write to offset 0x00 sets `pin_o[n]` for every bit n that is 1 in `wdata_i`; every other pin keeps its output level.
- R3: A write to offset 0x10 clears `pin_o[n]` for every bit n that is 1 in `wdata_i`; every other pin keeps its output level.
- R4: A write to offset 0x20 sets `pin_oe_o[n]` for every bit n that is 1 in `wdata_i`; all other enables keep their value.
- R5: A write to offset 0x30 clears `pin_oe_o[n]` for every bit n that is 1 in `wdata_i`; all other enables keep their value.
- R6: A read of offset 0x40 returns the synchronized input level, with `pin_i[n]` at bit n. A level held on `pin_i` across two rising clock edges before the read is returned by that read.
- R7: A read of offset 0x00 or 0x10 returns the output levels. A read of offset 0x20 or 0x30 returns the driver enables. Bits at NUM_PINS and above read as zero, whatever was written to them.
- R8: A read of any offset other than 0x00, 0x10, 0x20, 0x30 or 0x40 returns zero. A write to such an offset, or to 0x40, leaves `pin_o` and `pin_oe_o` unchanged.
- R9: With `req_i` low, `pin_o`, `pin_oe_o` and `rdata_o` do not change, whatever `we_i`, `addr_i` and `wdata_i` carry. A write does not change `rdata_o`.
- R10: A write changes `pin_o` and `pin_oe_o` only on the rising clock edge that accepts it, and not combinationally before that edge. A read updates `rdata_o` on the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data, bit n addresses pin n |
| rdata_o | output | DATA_W | Read data, valid after the accepting edge and held until the next read |
| pin_i | input | NUM_PINS | Asynchronous pin input levels |
| pin_o | output | NUM_PINS | Pin output levels |
| pin_oe_o | output | NUM_PINS | Pin output driver enables |

## Verification
The bench builds the block with NUM_PINS = 8 and leaves the bus 32 bits wide. With this setting every one of the 256 pin patterns can be swept through the set, clear and input registers. Known junk is also written into bits 31:8, so the zero fill of the unused upper read bits can be checked. Writes and reads to unmapped offsets and to the input register are checked against a model of the latches kept in the bench. Cycles with `req_i` low are checked the same way.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam logic [7:0] OFS_OUT_SET = 8'h00;
  localparam logic [7:0] OFS_OUT_CLR = 8'h10;
  localparam logic [7:0] OFS_DIR_SET = 8'h20;
  localparam logic [7:0] OFS_DIR_CLR = 8'h30;
  localparam logic [7:0] OFS_IN      = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT_SET,
    SEL_OUT_CLR,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_sc_latch.sv
// Set/clear latch; clear has priority when both hit the same bit.
module gpio_sc_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q | set_i) & ~clr_i;
  end

  assign q_o = q_q;

  // R2 / R4: set-only cycle ORs mask in, keeps other bits
  assert_set_keep_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> (q_o == ($past(q_o) | $past(set_i))));

  // R3 / R5: cleared bits are low next cycle, untouched bits keep value
  assert_clear_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

  assert_clear_keep_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i == '0) && (clr_i != '0)) |=> ((q_o & ~$past(clr_i)) == ($past(q_o) & ~$past(clr_i))));
endmodule

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode import gpio_sc_pkg::*; #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] out_q_i,
  input  logic [NUM_PINS-1:0] dir_q_i,
  input  logic [NUM_PINS-1:0] in_q_i,
  output logic [NUM_PINS-1:0] out_set_o,
  output logic [NUM_PINS-1:0] out_clr_o,
  output logic [NUM_PINS-1:0] dir_set_o,
  output logic [NUM_PINS-1:0] dir_clr_o,
  output logic                rd_en_o,
  output reg_sel_e            sel_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  reg_sel_e            sel;
  logic                wr_en;
  logic [NUM_PINS-1:0] mask;
  logic                unused_wdata;

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_OUT_SET)) sel = SEL_OUT_SET;
    else if (addr_i == ADDR_W'(OFS_OUT_CLR)) sel = SEL_OUT_CLR;
    else if (addr_i == ADDR_W'(OFS_DIR_SET)) sel = SEL_DIR_SET;
    else if (addr_i == ADDR_W'(OFS_DIR_CLR)) sel = SEL_DIR_CLR;
    else if (addr_i == ADDR_W'(OFS_IN))      sel = SEL_IN;
    else                                     sel = SEL_NONE;
  end

  assign wr_en        = req_i & we_i;
  assign rd_en_o      = req_i & ~we_i;
  assign mask         = wdata_i[NUM_PINS-1:0];
  assign unused_wdata = ^wdata_i;
  assign sel_o        = sel;

  assign out_set_o = (wr_en && sel == SEL_OUT_SET) ? mask : '0;
  assign out_clr_o = (wr_en && sel == SEL_OUT_CLR) ? mask : '0;
  assign dir_set_o = (wr_en && sel == SEL_DIR_SET) ? mask : '0;
  assign dir_clr_o = (wr_en && sel == SEL_DIR_CLR) ? mask : '0;

  always_comb begin
    unique case (sel)
      SEL_OUT_SET, SEL_OUT_CLR: rd_data_o = DATA_W'(out_q_i);
      SEL_DIR_SET, SEL_DIR_CLR: rd_data_o = DATA_W'(dir_q_i);
      SEL_IN:                   rd_data_o = DATA_W'(in_q_i);
      default:                  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank import gpio_sc_pkg::*; #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic [NUM_PINS-1:0] out_set, out_clr, dir_set, dir_clr;
  logic [NUM_PINS-1:0] out_q, dir_q, in_q;
  logic                rd_en;
  reg_sel_e            sel;
  logic [DATA_W-1:0]   rd_data;
  logic [DATA_W-1:0]   rdata_q;

  gpio_sc_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .out_q_i   (out_q),
    .dir_q_i   (dir_q),
    .in_q_i    (in_q),
    .out_set_o (out_set),
    .out_clr_o (out_clr),
    .dir_set_o (dir_set),
    .dir_clr_o (dir_clr),
    .rd_en_o   (rd_en),
    .sel_o     (sel),
    .rd_data_o (rd_data)
  );

  gpio_sc_latch #(.WIDTH(NUM_PINS)) u_out_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (out_set),
    .clr_i (out_clr),
    .q_o   (out_q)
  );

  gpio_sc_latch #(.WIDTH(NUM_PINS)) u_dir_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dir_set),
    .clr_i (dir_clr),
    .q_o   (dir_q)
  );

  gpio_sc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_data;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  assert_reset_state_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_o == '0 && pin_oe_o == '0 && rdata_o == '0));

  assert_input_read_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && sel == SEL_IN) |=> (rdata_o == DATA_W'($past(in_q))));

  assert_unmapped_zero_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && sel == SEL_NONE) |=> (rdata_o == '0));

  assert_no_write_side_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (sel == SEL_NONE || sel == SEL_IN)) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  assert_idle_stable_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(rdata_o)));

  assert_write_keeps_rdata_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> $stable(rdata_o));
endmodule

// File: tb/tb_gpio_sc_bank.sv
module tb_gpio_sc_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o;
  logic [N-1:0] pin_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [N-1:0] exp_out = '0;
  logic [N-1:0] exp_oe  = '0;
  logic [31:0]  rd_val;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_sc_bank #(.NUM_PINS(N), .ADDR_W(8), .DATA_W(32), .SYNC_STAGES(2)) dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pin_i   (pin_i),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; wdata_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R10 act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] odd_addrs [8];
    odd_addrs = '{8'h04, 8'h08, 8'h14, 8'h24, 8'h3C, 8'h44, 8'h80, 8'hFF};

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 pin_o after reset", 32'(pin_o), 32'h0);
    chk("R1 pin_oe_o after reset", 32'(pin_oe_o), 32'h0);
    chk("R1 rdata_o after reset", rdata_o, 32'h0);

    // R10: no combinational path from a write to the pins
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h00; wdata_i = 32'h1;
    #1;
    chk("R10 pin_o before accepting edge", 32'(pin_o), 32'h0);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk("R10 pin_o after accepting edge", 32'(pin_o), 32'h1);
    exp_out = 8'h01;

    // R2 R3 R7: output latch sweep with junk in the upper bits
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      c = 8'((v * 37 + 11) & 255);
      wr(8'h00, {24'hA5C3F1, 8'(v)});
      exp_out = exp_out | 8'(v);
      chk("R2 set output", 32'(pin_o), 32'(exp_out));
      chk("R4 oe untouched by output set", 32'(pin_oe_o), 32'(exp_oe));
      rd(8'h00, rd_val);
      chk("R7 read output via 0x00", rd_val, 32'(exp_out));
      wr(8'h10, {24'hFFFFFF, c});
      exp_out = exp_out & ~c;
      chk("R3 clear output", 32'(pin_o), 32'(exp_out));
      rd(8'h10, rd_val);
      chk("R7 read output via 0x10", rd_val, 32'(exp_out));
    end

    // R4 R5 R7: direction latch sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      c = 8'((v * 53 + 7) & 255);
      wr(8'h20, {24'h5A5A5A, 8'(v)});
      exp_oe = exp_oe | 8'(v);
      chk("R4 enable driver", 32'(pin_oe_o), 32'(exp_oe));
      chk("R2 output untouched by oe set", 32'(pin_o), 32'(exp_out));
      rd(8'h20, rd_val);
      chk("R7 read oe via 0x20", rd_val, 32'(exp_oe));
      wr(8'h30, {24'hFFFFFF, c});
      exp_oe = exp_oe & ~c;
      chk("R5 disable driver", 32'(pin_oe_o), 32'(exp_oe));
      rd(8'h30, rd_val);
      chk("R7 read oe via 0x30", rd_val, 32'(exp_oe));
    end

    // R6: input sweep through the synchronizer
    for (int v = 0; v < 256; v++) begin
      @(negedge clk_i);
      pin_i = 8'(v ^ 8'h96);
      @(negedge clk_i);
      @(negedge clk_i);
      rd(8'h40, rd_val);
      chk("R6 input read", rd_val, 32'(v ^ 8'h96));
    end

    // R8: unmapped offsets and writes to the input register
    wr(8'h00, 32'h0000_005A);
    wr(8'h10, 32'h0000_00A5);
    wr(8'h20, 32'h0000_00C3);
    wr(8'h30, 32'h0000_003C);
    exp_out = 8'h5A;
    exp_oe  = 8'hC3;
    chk("R8 setup output", 32'(pin_o), 32'(exp_out));
    wr(8'h40, 32'hFFFF_FFFF);
    chk("R8 write to 0x40 output", 32'(pin_o), 32'(exp_out));
    chk("R8 write to 0x40 oe", 32'(pin_oe_o), 32'(exp_oe));
    foreach (odd_addrs[i]) begin
      wr(odd_addrs[i], 32'hFFFF_FFFF);
      chk("R8 unmapped write output", 32'(pin_o), 32'(exp_out));
      chk("R8 unmapped write oe", 32'(pin_oe_o), 32'(exp_oe));
      rd(8'h00, rd_val);
      rd(odd_addrs[i], rd_val);
      chk("R8 unmapped read zero", rd_val, 32'h0);
    end

    // R9: idle cycles with write-looking data, and writes leave rdata_o alone
    rd(8'h20, rd_val);
    chk("R9 setup read", rd_val, 32'(exp_oe));
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b1; addr_i = 8'h10; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    addr_i = 8'h20;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 8'h40;
    @(negedge clk_i);
    chk("R9 idle keeps output", 32'(pin_o), 32'(exp_out));
    chk("R9 idle keeps oe", 32'(pin_oe_o), 32'(exp_oe));
    chk("R9 idle keeps rdata", rdata_o, 32'(exp_oe));
    wr(8'h00, 32'h0000_0001);
    exp_out = exp_out | 8'h01;
    chk("R9 write keeps rdata", rdata_o, 32'(exp_oe));
    chk("R2 final set", 32'(pin_o), 32'(exp_out));

    done = 1'b1;
    finish_run();
  end
endmodule